// File: doc/BRIEF.md
# Peak-and-Hold Solenoid PWM Controller

This block drives one solenoid channel. After reset it waits through a fixed start-up interval before it raises `ready`. Until then the on/off command has no effect. Once `ready` is high and `cmd` is high, the block runs a fixed-period PWM. The pulse width comes first from the peak setting byte. After a set number of clocks the block moves on its own to the hold setting byte, which lowers the coil's average current so the plunger is kept in place with less power.

Each PWM period the high-side pulse starts at the beginning of the period. It is cut short when the synchronized current-comparator input reports over-current. During a short blanking window at the start of the pulse the comparator is not looked at, so every pulse has a minimum width. The high-side and low-side gates are complementary, with a dead band in which both are off at every switch-over.

The active setting byte is also driven out as a reference code, for an external DAC that sets the comparator threshold. When `cmd` falls, both gates turn off in the same cycle. The next enable starts again with the peak setting.

Top module: `peak_hold_pwm`

## Requirements
- R1: `ready` is low out of reset. It goes high after exactly READY_CYCLES rising clock edges following reset release, and it then stays high.
- R2: Whenever `cmd` is low or `ready` is low, `hs_gate` and `ls_gate` are both low, without any clock delay. A command given before `ready` starts no sequence.
- R3: After the enable (`cmd` and `ready`) rises, `in_hold` stays low for PEAK_CYCLES rising edges and is high after PEAK_CYCLES+1 edges. It stays high for as long as the enable stays high.
- R4: When the enable falls, the phase returns to idle. The next enable starts with `in_hold` low and the peak byte selected.
- R5: The PWM period is 2^DUTY_BITS clocks (256 by default). When the comparator is low and the selected byte is D (1 to 255), `hs_gate` is high for D−DEAD_CYCLES clocks per period and `ls_gate` is high for max(0, 256−D−DEAD_CYCLES) clocks per period.
- R6: The comparator input passes through two flip-flops. It is ignored while the period counter is below DEAD_CYCLES+BLANK_CYCLES. Once it trips inside the pulse, the pulse stays off until the period ends. With the comparator held high, `hs_gate` is high for BLANK_CYCLES clocks per period.
- R7: `hs_gate` and `ls_gate` are never high together. In the cycle where either gate falls, the other is low.
- R8: `ref_code` equals `hold_cfg` while `in_hold` is high, and equals `peak_cfg` otherwise.
- R9: A selected byte of 0 keeps `hs_gate` low for the whole period, and `ls_gate` is then high on all 256 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock (6.25 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd | input | 1 | Solenoid on/off command |
| cmp_in | input | 1 | Current comparator output; high means current above reference |
| peak_cfg | input | DUTY_BITS | Peak setting: pulse width in clocks and reference code |
| hold_cfg | input | DUTY_BITS | Hold setting: pulse width in clocks and reference code |
| ready | output | 1 | Start-up interval has elapsed |
| in_hold | output | 1 | High while the hold setting is in use |
| hs_gate | output | 1 | High-side transistor drive |
| ls_gate | output | 1 | Low-side transistor drive |
| ref_code | output | DUTY_BITS | Selected reference code for the external DAC |

## Verification
The assertions check on every cycle the properties that hold no matter what the stimulus is. These are: `ready` stays high once raised; the gates are off whenever the enable is off; the gates never overlap and each switch-over has a break; the phase never falls back from hold to peak while enabled; every enable starts in peak; and a zero byte never drives the high side. Only the bench's scenarios can show the things that are counted over time. These are the exact start-up and peak-interval lengths, the per-period on-times for several bytes (including 0 and 255), the cut-down pulse width under a comparator held high, and the recovery once the comparator is released.

// File: rtl/peak_hold_pwm.sv
`timescale 1ns/1ps
module peak_hold_pwm #(
  parameter int READY_CYCLES = 12500,
  parameter int PEAK_CYCLES  = 312500,
  parameter int BLANK_CYCLES = 2,
  parameter int DEAD_CYCLES  = 1,
  parameter int DUTY_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd,
  input  logic                 cmp_in,
  input  logic [DUTY_BITS-1:0] peak_cfg,
  input  logic [DUTY_BITS-1:0] hold_cfg,
  output logic                 ready,
  output logic                 in_hold,
  output logic                 hs_gate,
  output logic                 ls_gate,
  output logic [DUTY_BITS-1:0] ref_code
);
  localparam int RW = $clog2(READY_CYCLES + 1);
  localparam int TW = $clog2(PEAK_CYCLES + 1);
  localparam int DW = $clog2(DEAD_CYCLES + 1);
  localparam logic [DUTY_BITS:0] IGNORE_END = (DUTY_BITS+1)'(DEAD_CYCLES + BLANK_CYCLES);

  typedef enum logic [1:0] {PH_IDLE, PH_PEAK, PH_HOLD} phase_t;

  phase_t               phase;
  logic [RW-1:0]        rcnt;
  logic [TW-1:0]        tcnt;
  logic [DUTY_BITS-1:0] pcnt;
  logic [DW-1:0]        dcnt;
  logic                 cmp_m, cmp_s, chopped, side;
  logic                 en, in_pulse, blank_done, want_hs;

  assign en         = cmd & ready;
  assign in_hold    = (phase == PH_HOLD);
  assign ref_code   = in_hold ? hold_cfg : peak_cfg;
  assign in_pulse   = pcnt < ref_code;
  assign blank_done = {1'b0, pcnt} >= IGNORE_END;
  assign want_hs    = en & in_pulse & (~blank_done | (~cmp_s & ~chopped));
  assign hs_gate    = en & side  & (dcnt == '0);
  assign ls_gate    = en & ~side & (dcnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rcnt  <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      rcnt  <= rcnt + 1'b1;
      ready <= (rcnt == RW'(READY_CYCLES - 1));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= PH_IDLE;
      tcnt  <= '0;
    end else if (!en) begin
      phase <= PH_IDLE;
      tcnt  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase <= PH_PEAK;
          tcnt  <= '0;
        end
        PH_PEAK:
          if (tcnt == TW'(PEAK_CYCLES - 1)) phase <= PH_HOLD;
          else tcnt <= tcnt + 1'b1;
        default: phase <= PH_HOLD;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_m <= 1'b0;
      cmp_s <= 1'b0;
    end else begin
      cmp_m <= cmp_in;
      cmp_s <= cmp_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pcnt    <= '0;
      chopped <= 1'b0;
    end else if (!en) begin
      pcnt    <= '0;
      chopped <= 1'b0;
    end else begin
      pcnt <= pcnt + 1'b1;
      if (&pcnt) chopped <= 1'b0;
      else if (cmp_s & blank_done & in_pulse) chopped <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      side <= 1'b0;
      dcnt <= '0;
    end else if (!en) begin
      side <= 1'b0;
      dcnt <= '0;
    end else if (want_hs != side) begin
      side <= want_hs;
      dcnt <= DW'(DEAD_CYCLES);
    end else if (dcnt != '0) begin
      dcnt <= dcnt - 1'b1;
    end
endmodule

// File: rtl/peak_hold_pwm_chk.sv
`timescale 1ns/1ps
module peak_hold_pwm_chk #(
  parameter int DUTY_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd,
  input logic                 ready,
  input logic                 in_hold,
  input logic                 hs_gate,
  input logic                 ls_gate,
  input logic [DUTY_BITS-1:0] ref_code
);
  assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  assert_gates_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd && ready) |-> (!hs_gate && !ls_gate));

  assert_hold_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && cmd && ready) |=> in_hold);

  assert_peak_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd && ready) |=> !in_hold);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  assert_break_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_gate) |-> !ls_gate);

  assert_break_ls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_gate) |-> !hs_gate);

  assert_zero_duty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ref_code) == '0 && ref_code == '0) |-> !hs_gate);
endmodule

bind peak_hold_pwm peak_hold_pwm_chk #(.DUTY_BITS(DUTY_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .ready(ready), .in_hold(in_hold),
  .hs_gate(hs_gate), .ls_gate(ls_gate), .ref_code(ref_code)
);

// File: tb/sim_peak_hold_pwm.sv
`timescale 1ns/1ps
module sim_peak_hold_pwm;
  localparam int RDY  = 300;
  localparam int PK   = 2000;
  localparam int BLK  = 2;
  localparam int DEAD = 1;

  logic clk = 1'b0, rst_n = 1'b0, cmd = 1'b0, cmp_in = 1'b0;
  logic [7:0] peak_cfg = 8'd100, hold_cfg = 8'd40;
  logic ready, in_hold, hs_gate, ls_gate;
  logic [7:0] ref_code;
  int nchk = 0, nfail = 0, cyc = 0;
  int q_hs[$], q_ls[$];
  string q_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  peak_hold_pwm #(.READY_CYCLES(RDY), .PEAK_CYCLES(PK), .BLANK_CYCLES(BLK),
                  .DEAD_CYCLES(DEAD), .DUTY_BITS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmp_in(cmp_in),
    .peak_cfg(peak_cfg), .hold_cfg(hold_cfg), .ready(ready), .in_hold(in_hold),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .ref_code(ref_code));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_window(input int hs_n, input int ls_n, input string tag);
    q_hs.push_back(hs_n);
    q_ls.push_back(ls_n);
    q_tag.push_back(tag);
    wait (q_hs.size() == 0);
  endtask

  initial begin
    forever begin
      int hc, lc;
      wait (q_hs.size() != 0);
      hc = 0; lc = 0;
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        hc += int'(hs_gate);
        lc += int'(ls_gate);
      end
      chk(hc == q_hs[0], {q_tag[0], " hs count"}, hc, q_hs[0]);
      chk(lc == q_ls[0], {q_tag[0], " ls count"}, lc, q_ls[0]);
      void'(q_hs.pop_front());
      void'(q_ls.pop_front());
      void'(q_tag.pop_front());
    end
  end

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 reset ready", ready, 0);
    chk(!hs_gate && !ls_gate, "R2 reset gates", hs_gate + ls_gate, 0);
    chk(in_hold == 1'b0, "R3 reset phase", in_hold, 0);
    rst_n = 1'b1;
    cmd = 1'b1;
    c0 = cyc;
    while (cyc - c0 < RDY - 1) @(negedge clk);
    chk(ready == 1'b0, "R1 ready before interval", ready, 0);
    chk(!hs_gate && !ls_gate, "R2 command before ready", hs_gate + ls_gate, 0);
    cmd = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready at interval", ready, 1);
    chk(!hs_gate && !ls_gate && !in_hold, "R2 no start after early command", hs_gate + ls_gate + in_hold, 0);

    @(negedge clk);
    cmd = 1'b1;
    c0 = cyc;
    #1 chk(ref_code == 8'd100, "R8 peak code", ref_code, 100);
    repeat (256) @(negedge clk);
    expect_window(100 - DEAD, 256 - 100 - DEAD, "R5 peak");
    while (cyc - c0 < PK) @(negedge clk);
    chk(in_hold == 1'b0, "R3 still peak", in_hold, 0);
    @(negedge clk);
    chk(in_hold == 1'b1, "R3 hold reached", in_hold, 1);
    chk(ref_code == 8'd40, "R8 hold code", ref_code, 40);
    repeat (256) @(negedge clk);
    expect_window(40 - DEAD, 256 - 40 - DEAD, "R5 hold");

    cmp_in = 1'b1;
    repeat (256) @(negedge clk);
    expect_window(BLK, 256 - (DEAD + BLK) - DEAD, "R6 chopped");
    cmp_in = 1'b0;
    repeat (256) @(negedge clk);
    expect_window(40 - DEAD, 256 - 40 - DEAD, "R6 released");
    chk(in_hold == 1'b1, "R3 hold kept", in_hold, 1);

    cmd = 1'b0;
    #1 chk(!hs_gate && !ls_gate, "R2 immediate off", hs_gate + ls_gate, 0);
    repeat (5) @(negedge clk);
    chk(in_hold == 1'b0, "R4 idle after drop", in_hold, 0);
    cmd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(in_hold == 1'b0, "R4 restart in peak", in_hold, 0);
    chk(ref_code == 8'd100, "R4 restart code", ref_code, 100);

    peak_cfg = 8'd255;
    repeat (256) @(negedge clk);
    expect_window(255 - DEAD, 0, "R5 full byte");
    peak_cfg = 8'd0;
    repeat (256) @(negedge clk);
    expect_window(0, 256, "R9 zero byte");
    chk(in_hold == 1'b0, "R3 peak not yet over", in_hold, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule